// File: doc/BRIEF.md
# Configurable PCM Audio Serial Transmitter

This block turns parallel audio samples into a serial stream made of a bit clock, a word select and up to three data lines. It derives the bit clock and the word select from the system clock by a fixed divide ratio. Each bit clock lasts `2*DIV` system clocks. A frame is 64 bit clocks: a 32-bit left slot followed by a 32-bit right slot. The audio word sits inside each slot according to the configured justification. Every bit of the slot outside the word is driven low.

A single 16-bit control word sets all framing options at run time:

- enable
- word size
- the bit-clock edge on which the outputs change
- word-select polarity
- one-bit delay
- start or end justification
- two or six channels
- bit order
- mute

Samples arrive over a valid/ready handshake in channel order. A frame's set of samples is staged before the frame begins. A new control word is applied only at a frame boundary, so no frame ever mixes two settings.

Top module: `pcm_serial_tx`

## Requirements
- R1: After reset the control word is all zeros, and `bclk_o`, `ws_o` and `sd_o` are low.
- R2: Control bits [2:1] select the word size W: 00 gives 16, 01 gives 18, 10 gives 20 and 11 gives 24. The word is the low-order W bits of the 24-bit sample.
- R3: Control bit 3 selects the edge on which data and word select change: 0 is the falling edge of `bclk_o` and 1 is the rising edge. Each bit lasts 2*DIV system clocks, and each clock level lasts DIV of them.
- R4: Control bit 4 sets word-select polarity. With 0, the left slot is sent with `ws_o` low and the right slot with it high. With 1, the levels are swapped.
- R5: With control bit 6 at 0 (start justified), the word's first bit is sent in the bit where `ws_o` changes when control bit 5 is 0. When control bit 5 is 1, it is sent one bit later.
- R6: With control bit 6 at 1 (end justified), the word's last bit is sent in the bit just before the `ws_o` transition when control bit 5 is 0. When control bit 5 is 1, it is sent in the bit just after the transition.
- R7: Every slot is 32 bits long, and every bit not covered by the word is low.
- R8: Control bit 7 at 0 gives two channels on `sd_o[0]`, with `sd_o[2:1]` held low. At 1 it gives six channels: samples 2k and 2k+1 of a frame form the left and right words of `sd_o[k]`.
- R9: Control bit 8 at 0 sends the word MSB first, and at 1 sends it LSB first.
- R10: Control bit 9 forces all data lines low while the clocks keep running. Samples are still consumed.
- R11: Control bit 0 enables output, and frames start on the first bit clock after enabling. After disabling, the current frame finishes and then all outputs are held low.
- R12: A control write made during a frame takes effect from the next frame on.
- R13: `smp_ready` is high while fewer samples are staged than the configured channel count. A frame that starts with too few samples staged sends all-zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 16 | Control word value |
| smp_valid | input | 1 | Sample valid |
| smp_data | input | 24 | Sample, word in low-order bits |
| smp_ready | output | 1 | Block can accept a sample |
| bclk_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word select |
| sd_o | output | 3 | Serial data lines |

## Verification
All serial outputs are registered, so they appear one system clock after the internal bit and frame counters move. The bench therefore samples them only on the receiving edge of `bclk_o`, in the middle of each bit, and not at a fixed cycle offset. The first receiving edge after the enable write carries bit 0 of the frame. The expected stream is built frame by frame from the control word in force for that frame, and it includes the underrun frame that follows the last staged samples. A mid-frame write is expected to show up only from the next 64-bit frame on. The spacing between receiving edges is checked to be exactly 2*DIV clocks, and after a disable the lines are checked only once the running frame has had time to end.

// File: rtl/pcm_serial_tx.sv
module pcm_serial_tx #(
  parameter int DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_we,
  input  logic [15:0] ctrl_wdata,
  input  logic        smp_valid,
  input  logic [23:0] smp_data,
  output logic        smp_ready,
  output logic        bclk_o,
  output logic        ws_o,
  output logic [2:0]  sd_o
);
  localparam int PW    = $clog2(2 * DIV);
  localparam int LINES = 3;
  localparam int NSMP  = 2 * LINES;
  localparam logic [PW-1:0] PH_LAST = PW'(2 * DIV - 1);
  localparam logic [PW-1:0] PH_HALF = PW'(DIV);
  localparam int B_EN = 0, B_EDGE = 3, B_WPOL = 4, B_DLY = 5,
                 B_END = 6, B_SIX = 7, B_LSB = 8, B_MUTE = 9;

  logic [15:0]   pend, cfg;
  logic          run;
  logic [PW-1:0] ph;
  logic [5:0]    q;
  logic [2:0]    cnt;
  logic [23:0]   stage [NSMP];
  logic [23:0]   held  [NSMP];

  logic [2:0] need;
  logic       full, take, wrap, fend, start, load;
  assign need      = pend[B_SIX] ? 3'd6 : 3'd2;
  assign full      = cnt >= need;
  assign smp_ready = !full;
  assign take      = smp_valid && smp_ready;
  assign wrap      = run && ph == PH_LAST;
  assign fend      = wrap && q == 6'd63;
  assign start     = !run && pend[B_EN];
  assign load      = start || (fend && pend[B_EN]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      cfg  <= '0;
      run  <= 1'b0;
      ph   <= '0;
      q    <= '0;
      cnt  <= '0;
      for (int i = 0; i < NSMP; i++) begin
        held[i]  <= '0;
        stage[i] <= '0;
      end
    end else begin
      if (ctrl_we) pend <= ctrl_wdata;
      if (start) run <= 1'b1;
      else if (fend && !pend[B_EN]) run <= 1'b0;
      if (!run || wrap) ph <= '0;
      else ph <= ph + 1'b1;
      if (start) q <= '0;
      else if (wrap) q <= q + 6'd1;
      if (load) begin
        cfg <= pend;
        for (int i = 0; i < NSMP; i++) held[i] <= full ? stage[i] : '0;
      end
      if (load && full) cnt <= '0;
      else if (take) begin
        stage[cnt] <= smp_data;
        cnt <= cnt + 3'd1;
      end
    end
  end

  logic [4:0] wbits, lead, o, idx, bpos;
  logic [5:0] qd;
  logic       in_word;
  logic [LINES-1:0] sd_nx;

  always_comb begin
    case (cfg[2:1])
      2'd0:    wbits = 5'd16;
      2'd1:    wbits = 5'd18;
      2'd2:    wbits = 5'd20;
      default: wbits = 5'd24;
    endcase
  end

  assign lead    = 5'(6'd32 - {1'b0, wbits});
  assign o       = q[4:0];
  assign qd      = q + {5'd0, cfg[B_DLY]};
  assign in_word = cfg[B_END] ? (o >= lead) : (o < wbits);
  assign idx     = cfg[B_END] ? (o - lead) : o;
  assign bpos    = cfg[B_LSB] ? idx : (wbits - 5'd1 - idx);

  for (genvar k = 0; k < LINES; k++) begin : g_line
    logic [23:0] s;
    assign s = q[5] ? held[2*k+1] : held[2*k];
    assign sd_nx[k] = (k == 0 || cfg[B_SIX]) && !cfg[B_MUTE] && in_word && s[bpos];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_o <= 1'b0;
      ws_o   <= 1'b0;
      sd_o   <= '0;
    end else if (!run) begin
      bclk_o <= 1'b0;
      ws_o   <= 1'b0;
      sd_o   <= '0;
    end else begin
      bclk_o <= (ph < PH_HALF) ? cfg[B_EDGE] : ~cfg[B_EDGE];
      ws_o   <= qd[5] ^ cfg[B_WPOL];
      sd_o   <= sd_nx;
    end
  end

  a_r11_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> (!bclk_o && !ws_o && sd_o == 3'b000));
  a_r8_two_ch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg[B_SIX]) |-> sd_o[2:1] == 2'b00);
  a_r10_mute_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg[B_MUTE]) |-> sd_o == 3'b000);
  a_r12_cfg_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && q != 6'd0) |-> $stable(cfg));
  a_r3_ws_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && $past(run, 2) && !$stable(ws_o)) |-> !$stable(bclk_o));
  a_r13_stage_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 3'd6);
endmodule

// File: tb/sim_pcm_serial_tx.sv
`timescale 1ns/1ps
module sim_pcm_serial_tx;
  localparam int DIV  = 2;
  localparam int BITT = 2 * DIV;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctrl_we;
  logic [15:0] ctrl_wdata;
  logic        smp_valid;
  logic [23:0] smp_data;
  logic        smp_ready;
  logic        bclk_o, ws_o;
  logic [2:0]  sd_o;

  always #2.5 clk = ~clk;

  pcm_serial_tx #(.DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .smp_valid(smp_valid), .smp_data(smp_data), .smp_ready(smp_ready),
    .bclk_o(bclk_o), .ws_o(ws_o), .sd_o(sd_o)
  );

  int checks = 0, errors = 0, cyc = 0, last_edge = -1, pos = 0;
  logic [3:0]  expq [$];
  string       tagq [$];
  logic        mon_on = 1'b0, mon_pol = 1'b0, prev_b = 1'b0;
  logic [23:0] fs [6];

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (mon_on && bclk_o != prev_b && bclk_o == ~mon_pol && expq.size() > 0) begin
      logic [3:0] e;
      string t;
      e = expq.pop_front();
      t = tagq.pop_front();
      check({ws_o, sd_o} == e, t, $sformatf("bit %0d {ws,sd}", pos), {ws_o, sd_o}, e);
      if (last_edge >= 0)
        check(cyc - last_edge == BITT, "R3", "bit period", cyc - last_edge, BITT);
      last_edge = cyc;
      pos++;
    end
    prev_b = bclk_o;
  end

  function automatic logic [23:0] smp(int f, int ch, int seed);
    logic [31:0] x;
    x = (f * 6 + ch + seed * 17 + 1) * 32'h9E3779B1;
    return x[31:8];
  endfunction

  function automatic logic [3:0] exp_bit(logic [15:0] c, int q, bit have);
    int w, d, o, side, p;
    logic [3:0] r;
    w = (c[2:1] == 2'd0) ? 16 : (c[2:1] == 2'd1) ? 18 : (c[2:1] == 2'd2) ? 20 : 24;
    d = c[5] ? 1 : 0;
    side = q / 32;
    o = q % 32;
    r = 4'b0;
    r[3] = (((q + d) % 64) >= 32) ^ c[4];
    for (int k = 0; k < 3; k++) begin
      logic [23:0] s;
      bit ok;
      s = fs[2*k+side];
      if (!c[6]) begin p = o; ok = o < w; end
      else begin p = o - (32 - w); ok = o >= 32 - w; end
      if (ok && have && !c[9] && (k == 0 || c[7]))
        r[k] = c[8] ? s[p] : s[w-1-p];
    end
    return r;
  endfunction

  task automatic wctl(logic [15:0] v);
    @(negedge clk);
    ctrl_we = 1'b1;
    ctrl_wdata = v;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic push(logic [23:0] s);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_data = s;
    while (!smp_ready) @(negedge clk);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic run_case(logic [15:0] c, int nf, int seed, bit mute_mid, string tag);
    int nch;
    bit ok;
    nch = c[7] ? 6 : 2;
    for (int f = 0; f <= nf; f++) begin
      logic [15:0] cf;
      string t;
      for (int ch = 0; ch < 6; ch++) fs[ch] = (f < nf) ? smp(f, ch, seed) : 24'd0;
      cf = (mute_mid && f >= 1) ? (c | 16'h0200) : c;
      t = (f == nf) ? "R13 underrun" : (mute_mid && f >= 1) ? "R10/R12 mute" : tag;
      for (int q = 0; q < 64; q++) begin
        expq.push_back(exp_bit(cf, q, f < nf));
        tagq.push_back(t);
      end
    end
    wctl(c);
    last_edge = -1;
    pos = 0;
    fork
      begin
        for (int f = 0; f < nf; f++)
          for (int ch = 0; ch < nch; ch++) push(smp(f, ch, seed));
      end
      begin
        @(negedge clk);
        while (smp_ready) @(negedge clk);
        mon_pol = c[3];
        mon_on = 1'b1;
        wctl(c | 16'h0001);
        if (mute_mid) begin
          repeat (100) @(negedge clk);
          wctl(c | 16'h0201);
        end
        while (expq.size() > 0) @(negedge clk);
        wctl(16'h0000);
      end
    join
    repeat (3 * 64 * BITT) @(negedge clk);
    mon_on = 1'b0;
    ok = 1;
    repeat (40) begin
      @(negedge clk);
      if (bclk_o || ws_o || sd_o != 3'b000) ok = 0;
    end
    check(ok, "R11", "outputs idle after disable", {bclk_o, ws_o, sd_o}, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    ctrl_we = 1'b0;
    ctrl_wdata = '0;
    smp_valid = 1'b0;
    smp_data = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({bclk_o, ws_o, sd_o} == 5'b0, "R1", "reset outputs", {bclk_o, ws_o, sd_o}, 0);
    check(smp_ready == 1'b1, "R13", "ready after reset", smp_ready, 1);
    run_case(16'h0000, 2, 1, 0, "R2/R5/R7 16b start");
    run_case(16'h0032, 2, 2, 0, "R4/R5 18b delayed");
    run_case(16'h0044, 2, 3, 0, "R3/R6 20b end");
    run_case(16'h0166, 2, 4, 0, "R6/R9 24b end delayed lsb");
    run_case(16'h00A0, 2, 5, 0, "R8 six ch delayed");
    run_case(16'h019E, 2, 6, 0, "R8/R9 six ch 24b lsb");
    run_case(16'h0004, 2, 7, 1, "R12 before mute");
    check(expq.size() == 0, "R11", "all expected bits seen", expq.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule